// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block sits beside a processor core and turns pending interrupt requests into a timed exception entry. It watches three classes of source: one non-maskable line, a set of on-chip peripheral lines and a set of external pin lines. Each maskable line carries its own priority level. When a request is eligible, the block takes it and runs a fixed series of judgment states whose length depends on the source class and on whether a block-transfer controller could have served the request. It then holds until the core reports that its current sequence is over.

After that wait, the block runs the entry itself. It writes the status word to the stack, then writes the return address, then reads the handler address from the vector table. Each of these three accesses goes over a request/ready memory port that may stall for any number of states. Once the status word has been saved, the block raises the interrupt mask so that requests of equal or lower level cannot nest. After the vector read it hands the handler address and the new stack pointer to the core in a one-cycle start pulse. The latency from acceptance to that pulse is exact and follows from the source class, the stall counts and the core's wait.

Top module: `irq_entry_seq`

## Requirements
- R1: The non-maskable source is always eligible. A maskable source is eligible only when its level is strictly greater than the mask field, bits [7:4] of `sr_in`. An ineligible request raises neither `acc_valid` nor `mem_req`.
- R2: Sources are indexed 0 for non-maskable, 1..NP for peripheral line p at index 1+p, and NP+1.. for pin line i at index NP+1+i. Among eligible requests the highest level wins, with the non-maskable source counting as level 15. On a tie the lower index wins. `acc_valid` pulses one cycle after the accepting edge, with the winner in `acc_src`.
- R3: The judgment phase lasts 2 cycles for the non-maskable and peripheral sources, plus 1 when the source's `xfer_cap` bit is 1. It lasts 4 cycles for pin sources, whatever their `xfer_cap` bit.
- R4: `cpu_seq_done` is sampled at the edge that ends the judgment phase and at every later edge. The entry starts after the first edge at which it is 1, so each edge at which it is 0 adds one wait cycle.
- R5: The entry performs three accesses in this order: a write of `sr_in` to sp-4, a write of `pc_in` to sp-8, and a read at vbr + 4*vector. The vector is 11 for non-maskable, 64+p for peripheral p and 32+i for pin i. `mem_we` is 1 for writes.
- R6: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the cycle `mem_req` rises until the edge at which `mem_rdy` is 1. An access lasts m cycles, where m is the number of cycles with `mem_req` high.
- R7: If the accepting edge is cycle 0, `handler_go` is high in cycle L+X+5+m1+m2+m3. L is the judgment length and X is the wait count.
- R8: With `handler_go`, `handler_pc` carries the data returned by the vector read and `handler_sp` equals sp-8.
- R9: `sr_wr` pulses in the cycle after the status write completes. `sr_new` is then equal to the saved status word with its mask field replaced by the accepted level (15 for non-maskable).
- R10: After reset the block is idle with all pulses and `mem_req` low. While an entry is running no further request is accepted. A request still pending is taken one edge after the `handler_go` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request |
| per_req | input | NP | Peripheral request lines |
| per_lvl | input | NP*LW | Peripheral levels, line p at [p*LW +: LW] |
| irq_req | input | NI | External pin request lines |
| irq_lvl | input | NI*LW | Pin levels, line i at [i*LW +: LW] |
| xfer_cap | input | 1+NP+NI | Per-source flag: a transfer controller could serve it |
| cpu_seq_done | input | 1 | Core's current sequence has finished |
| sr_in | input | XLEN | Current status word |
| pc_in | input | XLEN | Return address to save |
| sp_in | input | XLEN | Current stack pointer |
| vbr_in | input | XLEN | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data |
| mem_rdy | input | 1 | Access completes at this edge |
| acc_valid | output | 1 | Acceptance pulse |
| acc_src | output | SW | Accepted source index |
| sr_wr | output | 1 | Mask update pulse |
| sr_new | output | XLEN | Status word with raised mask |
| handler_go | output | 1 | Start handler fetch pulse |
| handler_pc | output | XLEN | Handler address |
| handler_sp | output | XLEN | Stack pointer after the saves |

## Verification
A wrong judgment count or a wrong wait decision does not change any address. It shows only as a `handler_go` pulse on the wrong cycle, so the bench times every entry against its computed latency, and the slip becomes visible at most a few cycles after the expected pulse. A wrong latched source or vector shows at the third access as a wrong read address, and one class of error shows one cycle after acceptance as a wrong `acc_src`. A corrupted stack pointer or saved word shows at the first access. The sweep covers every source, both transfer flags, several stall patterns and several core waits.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_JUDGE, S_WAIT, S_PREP1, S_PREP2, S_SAVE_SR,
    S_GAP1, S_SAVE_PC, S_GAP2, S_VEC, S_LOAD, S_GO
  } entry_state_t;

  typedef enum logic [1:0] {CLS_NMI, CLS_PER, CLS_IRQ} src_class_t;

  // judgment length: optional transfer check plus priority compare
  function automatic logic [2:0] judge_cycles(src_class_t cls, logic xcap);
    logic [2:0] n;
    if (cls == CLS_IRQ) n = 3'd4;
    else                n = xcap ? 3'd3 : 3'd2;
    return n;
  endfunction

endpackage

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
  import irq_entry_pkg::*;
#(
  parameter int NP = 4,
  parameter int NI = 4,
  parameter int LW = 4,
  parameter int SW = 4
) (
  input  logic               nmi_req,
  input  logic [NP-1:0]      per_req,
  input  logic [NP*LW-1:0]   per_lvl,
  input  logic [NI-1:0]      irq_req,
  input  logic [NI*LW-1:0]   irq_lvl,
  input  logic [LW-1:0]      mask,
  output logic               found,
  output logic [SW-1:0]      win_idx,
  output logic [LW-1:0]      win_lvl,
  output src_class_t         win_cls
);
  localparam int NS = 1 + NP + NI;

  logic [NS-1:0] req_a;
  logic [LW-1:0] lvl_a [NS];

  assign req_a[0] = nmi_req;
  assign lvl_a[0] = {LW{1'b1}};

  genvar g;
  generate
    for (g = 0; g < NP; g++) begin : g_per
      assign req_a[1+g] = per_req[g];
      assign lvl_a[1+g] = per_lvl[g*LW +: LW];
    end
    for (g = 0; g < NI; g++) begin : g_irq
      assign req_a[1+NP+g] = irq_req[g];
      assign lvl_a[1+NP+g] = irq_lvl[g*LW +: LW];
    end
  endgenerate

  // strict greater-than keeps the lower index on a tie
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int s = 0; s < NS; s++) begin
      if (req_a[s] && (s == 0 || lvl_a[s] > mask) &&
          (!found || lvl_a[s] > win_lvl)) begin
        found   = 1'b1;
        win_idx = SW'(s);
        win_lvl = lvl_a[s];
      end
    end
  end

  always_comb begin
    if (win_idx == '0)             win_cls = CLS_NMI;
    else if (win_idx <= SW'(NP))   win_cls = CLS_PER;
    else                           win_cls = CLS_IRQ;
  end

endmodule

// File: rtl/irq_bus_port.sv
module irq_bus_port #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            start_we,
  input  logic [XLEN-1:0] start_addr,
  input  logic [XLEN-1:0] start_wdata,
  input  logic            mem_rdy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (start) begin
      mem_req   <= 1'b1;
      mem_we    <= start_we;
      mem_addr  <= start_addr;
      mem_wdata <= start_wdata;
    end else if (mem_req && mem_rdy) begin
      mem_req   <= 1'b0;
    end
  end

  assign done = mem_req & mem_rdy;

  // R6
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_we) &&
                               $stable(mem_addr) && $stable(mem_wdata)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int NP       = 4,
  parameter int NI       = 4,
  parameter int LW       = 4,
  parameter int MASK_LSB = 4,
  parameter int XLEN     = 32,
  parameter int VW       = 8,
  parameter int VEC_NMI  = 11,
  parameter int VEC_PER  = 64,
  parameter int VEC_IRQ  = 32,
  localparam int NS      = 1 + NP + NI,
  localparam int SW      = $clog2(NS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nmi_req,
  input  logic [NP-1:0]      per_req,
  input  logic [NP*LW-1:0]   per_lvl,
  input  logic [NI-1:0]      irq_req,
  input  logic [NI*LW-1:0]   irq_lvl,
  input  logic [NS-1:0]      xfer_cap,
  input  logic               cpu_seq_done,
  input  logic [XLEN-1:0]    sr_in,
  input  logic [XLEN-1:0]    pc_in,
  input  logic [XLEN-1:0]    sp_in,
  input  logic [XLEN-1:0]    vbr_in,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic [XLEN-1:0]    mem_rdata,
  input  logic               mem_rdy,
  output logic               acc_valid,
  output logic [SW-1:0]      acc_src,
  output logic               sr_wr,
  output logic [XLEN-1:0]    sr_new,
  output logic               handler_go,
  output logic [XLEN-1:0]    handler_pc,
  output logic [XLEN-1:0]    handler_sp
);
  localparam logic [XLEN-1:0] MASK_FIELD =
    {{(XLEN-LW){1'b0}}, {LW{1'b1}}} << MASK_LSB;

  entry_state_t    state;
  logic [2:0]      cnt;
  logic [LW-1:0]   w_lvl;
  logic [VW-1:0]   w_vec;
  logic [XLEN-1:0] sr_lat, pc_lat, sp_lat, vbr_lat;

  logic            found;
  logic [SW-1:0]   win_idx;
  logic [LW-1:0]   win_lvl;
  src_class_t      win_cls;
  logic [VW-1:0]   vec_sel;

  logic            bp_start, bp_we, bus_done;
  logic [XLEN-1:0] bp_addr, bp_wdata;

  irq_src_arbiter #(.NP(NP), .NI(NI), .LW(LW), .SW(SW)) u_arb (
    .nmi_req (nmi_req),
    .per_req (per_req),
    .per_lvl (per_lvl),
    .irq_req (irq_req),
    .irq_lvl (irq_lvl),
    .mask    (sr_in[MASK_LSB +: LW]),
    .found   (found),
    .win_idx (win_idx),
    .win_lvl (win_lvl),
    .win_cls (win_cls)
  );

  always_comb begin
    case (win_cls)
      CLS_NMI: vec_sel = VW'(VEC_NMI);
      CLS_PER: vec_sel = VW'(VEC_PER) + VW'(win_idx) - VW'(1);
      default: vec_sel = VW'(VEC_IRQ) + VW'(win_idx) - VW'(1 + NP);
    endcase
  end

  // access launch: issued in the fixed state before each access
  always_comb begin
    bp_start = (state == S_PREP2) || (state == S_GAP1) || (state == S_GAP2);
    bp_we    = (state != S_GAP2);
    case (state)
      S_PREP2: begin
        bp_addr  = sp_lat - XLEN'(4);
        bp_wdata = sr_lat;
      end
      S_GAP1: begin
        bp_addr  = sp_lat - XLEN'(8);
        bp_wdata = pc_lat;
      end
      default: begin
        bp_addr  = vbr_lat + (XLEN'(w_vec) << 2);
        bp_wdata = '0;
      end
    endcase
  end

  irq_bus_port #(.XLEN(XLEN)) u_bus (
    .clk         (clk),
    .rst         (rst),
    .start       (bp_start),
    .start_we    (bp_we),
    .start_addr  (bp_addr),
    .start_wdata (bp_wdata),
    .mem_rdy     (mem_rdy),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done        (bus_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      w_lvl      <= '0;
      w_vec      <= '0;
      sr_lat     <= '0;
      pc_lat     <= '0;
      sp_lat     <= '0;
      vbr_lat    <= '0;
      acc_valid  <= 1'b0;
      acc_src    <= '0;
      sr_wr      <= 1'b0;
      sr_new     <= '0;
      handler_go <= 1'b0;
      handler_pc <= '0;
      handler_sp <= '0;
    end else begin
      acc_valid  <= 1'b0;
      sr_wr      <= 1'b0;
      handler_go <= 1'b0;
      case (state)
        S_IDLE: if (found) begin
          state     <= S_JUDGE;
          cnt       <= judge_cycles(win_cls, xfer_cap[win_idx]) - 3'd1;
          w_lvl     <= win_lvl;
          w_vec     <= vec_sel;
          acc_valid <= 1'b1;
          acc_src   <= win_idx;
        end
        S_JUDGE: begin
          if (cnt != '0)          cnt   <= cnt - 3'd1;
          else if (cpu_seq_done)  state <= S_PREP1;
          else                    state <= S_WAIT;
        end
        S_WAIT: if (cpu_seq_done) state <= S_PREP1;
        S_PREP1: begin
          sr_lat  <= sr_in;
          pc_lat  <= pc_in;
          sp_lat  <= sp_in;
          vbr_lat <= vbr_in;
          state   <= S_PREP2;
        end
        S_PREP2: state <= S_SAVE_SR;
        S_SAVE_SR: if (bus_done) begin
          sr_wr  <= 1'b1;
          sr_new <= (sr_lat & ~MASK_FIELD) | (XLEN'(w_lvl) << MASK_LSB);
          state  <= S_GAP1;
        end
        S_GAP1: state <= S_SAVE_PC;
        S_SAVE_PC: if (bus_done) state <= S_GAP2;
        S_GAP2: state <= S_VEC;
        S_VEC: if (bus_done) begin
          handler_pc <= mem_rdata;
          state      <= S_LOAD;
        end
        S_LOAD: begin
          handler_go <= 1'b1;
          handler_sp <= sp_lat - XLEN'(8);
          state      <= S_GO;
        end
        S_GO: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  accept_mask_chk: assert property (@(posedge clk) disable iff (rst)
    acc_valid |-> ((acc_src == '0) ||
                   (w_lvl > $past(sr_in[MASK_LSB +: LW]))));

  // R9
  mask_raise_chk: assert property (@(posedge clk) disable iff (rst)
    sr_wr |-> ($past(bus_done && mem_we) &&
               ($past(mem_addr) == sp_lat - XLEN'(4))));

  // R8
  handler_src_chk: assert property (@(posedge clk) disable iff (rst)
    handler_go |-> $past(mem_req && mem_rdy && !mem_we, 2));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_valid, sr_wr, handler_go}));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int NP = 4, NI = 4, LW = 4, NS = 9, SW = 4;
  localparam logic [31:0] RD_KEY = 32'h5A00_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic nmi_req = 1'b0;
  logic [NP-1:0] per_req = '0;
  logic [NP*LW-1:0] per_lvl = '0;
  logic [NI-1:0] irq_req = '0;
  logic [NI*LW-1:0] irq_lvl = '0;
  logic [NS-1:0] xfer_cap = '0;
  logic cpu_seq_done = 1'b1;
  logic [31:0] sr_in = 32'hA000_0003, pc_in = 32'h0000_1234;
  logic [31:0] sp_in = 32'h0000_8000, vbr_in = 32'h0001_0000;
  logic mem_req, mem_we, mem_rdy = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic acc_valid, sr_wr, handler_go;
  logic [SW-1:0] acc_src;
  logic [31:0] sr_new, handler_pc, handler_sp;

  int nchk = 0, nerr = 0;
  int mw [3];
  int midx = 0, mcnt = 0;
  logic [31:0] rec_addr [3], rec_wd [3];
  logic rec_we [3];
  int rec_m [3];

  always #5 clk = ~clk;
  assign mem_rdata = mem_addr ^ RD_KEY;

  irq_entry_seq u_dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .per_req(per_req),
    .per_lvl(per_lvl), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .xfer_cap(xfer_cap), .cpu_seq_done(cpu_seq_done), .sr_in(sr_in),
    .pc_in(pc_in), .sp_in(sp_in), .vbr_in(vbr_in), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy), .acc_valid(acc_valid),
    .acc_src(acc_src), .sr_wr(sr_wr), .sr_new(sr_new),
    .handler_go(handler_go), .handler_pc(handler_pc), .handler_sp(handler_sp)
  );

  // memory model: stalls access n for mw[n] cycles, records what it saw
  always @(negedge clk) begin
    if (acc_valid) begin
      midx = 0;
      mcnt = 0;
    end
    if (mem_req) begin
      if (mcnt == 0 && midx < 3) begin
        rec_addr[midx] = mem_addr;
        rec_wd[midx]   = mem_wdata;
        rec_we[midx]   = mem_we;
      end
      mcnt = mcnt + 1;
      mem_rdy = (midx < 3) ? (mcnt == mw[midx]) : 1'b1;
    end else begin
      if (mcnt != 0) begin
        if (midx < 3) rec_m[midx] = mcnt;
        midx = midx + 1;
      end
      mcnt = 0;
      mem_rdy = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", nchk + 1, nerr + 1);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_src(input int s);
    if (s == 0) nmi_req = 1'b0;
    else if (s <= NP) per_req[s-1] = 1'b0;
    else irq_req[s-1-NP] = 1'b0;
  endtask

  // called at a negedge with requests already driven
  task automatic run_case(input int src, input int lvl, input int m1,
                          input int m2, input int m3, input int w);
    int k, L, X, N, vec, srk;
    int acc_extra;
    logic [31:0] srv, vaddr, exp_sr;
    mw[0] = m1; mw[1] = m2; mw[2] = m3;
    cpu_seq_done = (w == 0);
    if (src <= NP) L = 2 + int'(xfer_cap[src]);
    else           L = 4;
    X = (w + 1 - L > 0) ? (w + 1 - L) : 0;
    N = L + X + 5 + m1 + m2 + m3;
    vec = (src == 0) ? 11 : (src <= NP) ? 64 + src - 1 : 32 + src - 1 - NP;
    vaddr = vbr_in + 32'(4 * vec);
    k = 0;
    do begin @(negedge clk); k++; end while (!acc_valid && k < 50);
    chk(acc_valid && (int'(acc_src) == src), "R2 winner", longint'(acc_src), src);
    clear_src(src);
    k = 0; srk = -1; srv = '0; acc_extra = 0;
    while (!handler_go && k < 300) begin
      @(negedge clk); k++;
      if (k == w) cpu_seq_done = 1'b1;
      if (sr_wr) begin srk = k; srv = sr_new; end
      if (acc_valid) acc_extra++;
    end
    chk(k == N, "R7 R3 R4 handler_go cycle", k, N);
    chk(srk == L + X + 2 + m1, "R9 sr_wr cycle", srk, L + X + 2 + m1);
    exp_sr = (sr_in & ~32'h0000_00F0) | (32'(lvl) << 4);
    chk(srv == exp_sr, "R9 sr_new", srv, exp_sr);
    chk(handler_pc == (vaddr ^ RD_KEY), "R8 handler_pc", handler_pc, vaddr ^ RD_KEY);
    chk(handler_sp == sp_in - 8, "R8 handler_sp", handler_sp, sp_in - 8);
    chk(midx == 3, "R5 access count", midx, 3);
    chk(rec_we[0] && rec_addr[0] == sp_in - 4 && rec_wd[0] == sr_in,
        "R5 SR save", rec_addr[0], sp_in - 4);
    chk(rec_we[1] && rec_addr[1] == sp_in - 8 && rec_wd[1] == pc_in,
        "R5 PC save", rec_addr[1], sp_in - 8);
    chk(!rec_we[2] && rec_addr[2] == vaddr, "R5 vector read", rec_addr[2], vaddr);
    chk(rec_m[0] == m1 && rec_m[1] == m2 && rec_m[2] == m3, "R6 access lengths",
        rec_m[0] * 256 + rec_m[1] * 16 + rec_m[2], m1 * 256 + m2 * 16 + m3);
    chk(acc_extra == 0, "R10 no accept while busy", acc_extra, 0);
  endtask

  task automatic set_src(input int s, input int lvl);
    if (s == 0) nmi_req = 1'b1;
    else if (s <= NP) begin
      per_req[s-1] = 1'b1; per_lvl[(s-1)*LW +: LW] = LW'(lvl);
    end else begin
      irq_req[s-1-NP] = 1'b1; irq_lvl[(s-1-NP)*LW +: LW] = LW'(lvl);
    end
  endtask

  initial begin
    int mset [3][3];
    int wset [3];
    int seen;
    mset[0] = '{1, 1, 1}; mset[1] = '{2, 3, 1}; mset[2] = '{1, 4, 2};
    wset = '{0, 3, 7};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(!mem_req && !acc_valid && !sr_wr && !handler_go, "R10 reset idle",
        {mem_req, acc_valid, sr_wr, handler_go}, 0);

    // sweep every source, transfer flag, stall pattern and core wait
    for (int s = 0; s < NS; s++)
      for (int xc = 0; xc < 2; xc++)
        for (int mi = 0; mi < 3; mi++)
          for (int wi = 0; wi < 3; wi++) begin
            int lvl;
            lvl = (s == 0) ? 15 : (s <= NP) ? s + 1 : s + 3;
            xfer_cap = xc ? '1 : '0;
            set_src(s, lvl);
            run_case(s, lvl, mset[mi][0], mset[mi][1], mset[mi][2], wset[wi]);
          end
    xfer_cap = '0;

    // R1: level equal to mask is refused
    @(negedge clk);
    sr_in = 32'hA000_0053;
    set_src(2, 5);
    seen = 0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (acc_valid || mem_req) seen++;
    end
    chk(seen == 0, "R1 equal level refused", seen, 0);
    set_src(2, 6);
    run_case(2, 6, 1, 2, 1, 0);

    // R1: mask 15 refuses pin level 15, non-maskable still taken
    sr_in = 32'hA000_00F3;
    set_src(5, 15);
    seen = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (acc_valid || mem_req) seen++;
    end
    chk(seen == 0, "R1 mask 15 refuses maskable", seen, 0);
    irq_req = '0;
    set_src(0, 15);
    run_case(0, 15, 2, 1, 1, 2);
    sr_in = 32'hA000_0003;

    // R2 tie: lower index wins, loser taken after entry (R10)
    set_src(2, 7); set_src(5, 7);
    run_case(2, 7, 1, 1, 1, 0);
    run_case(5, 7, 1, 1, 1, 0);
    // R2 higher level wins over lower index
    set_src(4, 8); set_src(7, 9);
    run_case(7, 9, 2, 2, 2, 4);
    run_case(4, 8, 1, 1, 1, 0);
    // R2 non-maskable beats peripheral at level 15
    set_src(1, 15); set_src(0, 15);
    run_case(0, 15, 1, 1, 1, 0);
    run_case(1, 15, 1, 3, 1, 1);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule